// File: doc/BRIEF.md
# Adaptive Dual-Mode QAM Symbol Mapper

This block turns groups of four payload bits into constellation points for a two-stream transmitter. A one-bit mode input chooses how each four-bit group is used. In one mode the group forms a single 16QAM symbol, which appears on output stream 1. In the other mode the group is split into two 2-bit halves, and each half becomes an independent QPSK symbol, one on output stream 1 and one on output stream 2. Each output carries signed 16-bit in-phase and quadrature samples. The amplitudes come from a small constant level table scaled by a parameter unit, not from a general multiplier.

The mode is decided elsewhere for each channel realisation, so it may change between frames but must never change within one. The block therefore takes the mode only on a symbol flagged as the start of a frame and holds it until the next start-of-frame symbol. One register stage separates the input handshake from the output.

Top module: `dual_qam_mapper`

## Requirements
- R1: While reset is high and in the cycle after it, `out_valid` and `s2_active` are 0 and all four sample outputs are 0.
- R2: A group accepted with `in_valid`=1 on a rising edge appears on the outputs, with `out_valid`=1, right after that edge (one register stage).
- R3: In 16QAM mode (mode value 0), bits [3:2] select I and bits [1:0] select Q on stream 1, with the Gray map 00→-3U, 01→-1U, 11→+1U, 10→+3U, where U is the UNIT parameter (default 4096).
- R4: In 16QAM mode, `s2_i` and `s2_q` are 0 and `s2_active` is 0.
- R5: In dual-QPSK mode (mode value 1), stream 1 takes I from bit 3 and Q from bit 2, and stream 2 takes I from bit 1 and Q from bit 0. A bit value of 1 maps to +U and 0 maps to -U. `s2_active` is 1.
- R6: The mode is sampled only from a group that has `in_sof`=1, and it applies to that group. A change of `mode_sel` without `in_sof` has no effect until the next start-of-frame group.
- R7: After reset, until the first start-of-frame group, the mode is 16QAM.
- R8: In a cycle with `in_valid`=0, the next output has `out_valid`=0 and `s2_active`=0, and the sample outputs keep their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Bit group valid |
| in_sof | input | 1 | Group is the first of a frame |
| in_bits | input | 4 | Payload bit group |
| mode_sel | input | 1 | 0 = one 16QAM stream, 1 = two QPSK streams |
| out_valid | output | 1 | Output samples valid |
| s1_i | output | 16 | Stream 1 in-phase |
| s1_q | output | 16 | Stream 1 quadrature |
| s2_i | output | 16 | Stream 2 in-phase |
| s2_q | output | 16 | Stream 2 quadrature |
| s2_active | output | 1 | Stream 2 carries a symbol |

## Verification
The hardest condition to reach from the ports is a mode change in the middle of a frame. It has to be shown that the change is held off and then takes effect on exactly the next start-of-frame group, and that the start-of-frame group itself already uses the new value. The stimulus opens a frame in 16QAM mode, raises `mode_sel` on the groups that follow without a start-of-frame flag, and checks that they stay single-stream. It then sends a start-of-frame group with the new mode and checks for the switch on that group. A separate scenario raises `mode_sel` right after reset with no start-of-frame flag, so that the reset default is checked.

// File: rtl/qmap_pkg.sv
package qmap_pkg;

    localparam int SAMPLE_W = 16;
    localparam int GROUP_W  = 4;
    localparam int LEVEL_W  = 3;

    typedef enum logic {
        MODE_QAM16 = 1'b0,
        MODE_QPSK2 = 1'b1
    } map_mode_e;

    typedef struct packed {
        logic signed [SAMPLE_W-1:0] i;
        logic signed [SAMPLE_W-1:0] q;
    } iq_t;

    // Gray-coded 4-level axis table, unit-free
    function automatic logic signed [LEVEL_W-1:0] qam16_axis(input logic [1:0] b);
        logic signed [LEVEL_W-1:0] lv;
        case (b)
            2'b00:   lv = -3'sd3;
            2'b01:   lv = -3'sd1;
            2'b11:   lv = 3'sd1;
            default: lv = 3'sd3;
        endcase
        return lv;
    endfunction

    function automatic logic signed [LEVEL_W-1:0] qpsk_axis(input logic b);
        return b ? 3'sd1 : -3'sd1;
    endfunction

    function automatic logic signed [SAMPLE_W-1:0] scale_level(
        input logic signed [LEVEL_W-1:0]  lv,
        input logic signed [SAMPLE_W-1:0] unit
    );
        logic signed [SAMPLE_W+LEVEL_W-1:0] prod;
        prod = lv * unit;
        return prod[SAMPLE_W-1:0];
    endfunction

endpackage

// File: rtl/qmap_mode_ctl.sv
module qmap_mode_ctl
    import qmap_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      in_valid,
    input  logic      in_sof,
    input  logic      mode_sel,
    output map_mode_e mode_eff
);
    map_mode_e mode_q;
    logic      take_new;

    assign take_new = in_valid && in_sof;
    assign mode_eff = take_new ? map_mode_e'(mode_sel) : mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_QAM16;
        end else if (take_new) begin
            mode_q <= map_mode_e'(mode_sel);
        end
    end
endmodule

// File: rtl/qmap_lut.sv
module qmap_lut
    import qmap_pkg::*;
#(
    parameter logic signed [SAMPLE_W-1:0] UNIT = 16'sd4096
)(
    input  logic [GROUP_W-1:0] bits,
    input  map_mode_e          mode,
    output iq_t                sym1,
    output iq_t                sym2,
    output logic               act2
);
    localparam int NSTREAM = 2;
    localparam int HALF_W  = GROUP_W / NSTREAM;

    iq_t qpsk_sym [NSTREAM];
    iq_t qam_sym;

    // one QPSK point per half of the group; stream 0 uses the upper half
    for (genvar s = 0; s < NSTREAM; s++) begin : g_qpsk
        localparam int TOP = GROUP_W - 1 - s * HALF_W;
        always_comb begin
            qpsk_sym[s].i = scale_level(qpsk_axis(bits[TOP]), UNIT);
            qpsk_sym[s].q = scale_level(qpsk_axis(bits[TOP-1]), UNIT);
        end
    end

    always_comb begin
        qam_sym.i = scale_level(qam16_axis(bits[3:2]), UNIT);
        qam_sym.q = scale_level(qam16_axis(bits[1:0]), UNIT);
    end

    always_comb begin
        if (mode == MODE_QPSK2) begin
            sym1 = qpsk_sym[0];
            sym2 = qpsk_sym[1];
            act2 = 1'b1;
        end else begin
            sym1 = qam_sym;
            sym2 = '0;
            act2 = 1'b0;
        end
    end
endmodule

// File: rtl/qmap_out_reg.sv
module qmap_out_reg
    import qmap_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  iq_t  sym1_d,
    input  iq_t  sym2_d,
    input  logic act2_d,
    output logic valid_q,
    output iq_t  sym1_q,
    output iq_t  sym2_q,
    output logic act2_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            act2_q  <= 1'b0;
            sym1_q  <= '0;
            sym2_q  <= '0;
        end else begin
            valid_q <= in_valid;
            act2_q  <= in_valid && act2_d;
            if (in_valid) begin
                sym1_q <= sym1_d;
                sym2_q <= sym2_d;
            end
        end
    end
endmodule

// File: rtl/dual_qam_mapper.sv
module dual_qam_mapper
    import qmap_pkg::*;
#(
    parameter logic signed [15:0] UNIT = 16'sd4096
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic        in_sof,
    input  logic [3:0]  in_bits,
    input  logic        mode_sel,
    output logic        out_valid,
    output logic [15:0] s1_i,
    output logic [15:0] s1_q,
    output logic [15:0] s2_i,
    output logic [15:0] s2_q,
    output logic        s2_active
);
    map_mode_e mode_eff;
    iq_t       sym1_d, sym2_d, sym1_q, sym2_q;
    logic      act2_d;

    qmap_mode_ctl u_mode (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .mode_sel (mode_sel),
        .mode_eff (mode_eff)
    );

    qmap_lut #(.UNIT(UNIT)) u_lut (
        .bits (in_bits),
        .mode (mode_eff),
        .sym1 (sym1_d),
        .sym2 (sym2_d),
        .act2 (act2_d)
    );

    qmap_out_reg u_oreg (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .sym1_d   (sym1_d),
        .sym2_d   (sym2_d),
        .act2_d   (act2_d),
        .valid_q  (out_valid),
        .sym1_q   (sym1_q),
        .sym2_q   (sym2_q),
        .act2_q   (s2_active)
    );

    assign s1_i = sym1_q.i;
    assign s1_q = sym1_q.q;
    assign s2_i = sym2_q.i;
    assign s2_q = sym2_q.q;
endmodule

// File: rtl/dual_qam_mapper_chk.sv
module dual_qam_mapper_chk #(
    parameter logic signed [15:0] UNIT = 16'sd4096
)(
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_sof,
    input logic        out_valid,
    input logic [15:0] s1_i,
    input logic [15:0] s2_i,
    input logic [15:0] s2_q,
    input logic        s2_active
);
    logic signed [15:0] u1, u3;
    assign u1 = UNIT;
    assign u3 = 16'(3 * UNIT);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);                                          // R2
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !s2_active));                        // R8
    AST_S2_ZERO_QAM16: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !s2_active) |-> (s2_i == 16'd0 && s2_q == 16'd0));  // R4
    AST_QAM16_LEVELS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !s2_active) |->
        (s1_i == u1 || s1_i == -u1 || s1_i == u3 || s1_i == -u3));        // R3
    AST_QPSK_LEVELS: assert property (@(posedge clk) disable iff (rst)
        s2_active |-> ((s2_i == u1 || s2_i == -u1) && (s2_q == u1 || s2_q == -u1))); // R5
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_sof && out_valid) |=> (s2_active == $past(s2_active))); // R6
    AST_ACTIVE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        s2_active |-> out_valid);                                         // R8
endmodule

bind dual_qam_mapper dual_qam_mapper_chk #(.UNIT(UNIT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .out_valid (out_valid),
    .s1_i      (s1_i),
    .s2_i      (s2_i),
    .s2_q      (s2_q),
    .s2_active (s2_active)
);

// File: tb/dual_qam_mapper_tb.sv
module dual_qam_mapper_tb_top;
    localparam int U = 4096;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_sof, mode_sel;
    logic [3:0]  in_bits;
    logic        out_valid, s2_active;
    logic [15:0] s1_i, s1_q, s2_i, s2_q;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dual_qam_mapper dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
        .in_bits(in_bits), .mode_sel(mode_sel), .out_valid(out_valid),
        .s1_i(s1_i), .s1_q(s1_q), .s2_i(s2_i), .s2_q(s2_q),
        .s2_active(s2_active)
    );

    // sign bit b1, magnitude 1 when b0 set, 3 otherwise (Gray axis)
    function automatic int gray_lvl(input logic [1:0] b);
        int mag = b[0] ? 1 : 3;
        return (b[1] ? mag : -mag) * U;
    endfunction

    function automatic int bit_lvl(input logic b);
        return b ? U : -U;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive one group, then sample the registered result
    task automatic push(input logic [3:0] b, input logic sof, input logic m);
        @(negedge clk);
        in_valid = 1'b1; in_bits = b; in_sof = sof; mode_sel = m;
        @(negedge clk);
    endtask

    task automatic expect_qam16(input string req, input logic [3:0] b);
        chk({req, " valid"}, int'(out_valid), 1);
        chk({req, " s1_i"}, int'($signed(s1_i)), gray_lvl(b[3:2]));
        chk({req, " s1_q"}, int'($signed(s1_q)), gray_lvl(b[1:0]));
        chk({req, " s2_i"}, int'($signed(s2_i)), 0);
        chk({req, " s2_q"}, int'($signed(s2_q)), 0);
        chk({req, " s2_active"}, int'(s2_active), 0);
    endtask

    task automatic expect_qpsk(input string req, input logic [3:0] b);
        chk({req, " valid"}, int'(out_valid), 1);
        chk({req, " s1_i"}, int'($signed(s1_i)), bit_lvl(b[3]));
        chk({req, " s1_q"}, int'($signed(s1_q)), bit_lvl(b[2]));
        chk({req, " s2_i"}, int'($signed(s2_i)), bit_lvl(b[1]));
        chk({req, " s2_q"}, int'($signed(s2_q)), bit_lvl(b[0]));
        chk({req, " s2_active"}, int'(s2_active), 1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; in_sof = 1'b0; in_bits = '0; mode_sel = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 s2_active", int'(s2_active), 0);
        chk("R1 s1_i", int'(s1_i), 0);
        chk("R1 s1_q", int'(s1_q), 0);
        chk("R1 s2_i", int'(s2_i), 0);
        chk("R1 s2_q", int'(s2_q), 0);
    endtask

    task automatic t_qam16_all();
        for (int v = 0; v < 16; v++) begin
            push(4'(v), v == 0, 1'b0);
            expect_qam16("R3 R4 R2", 4'(v));
        end
    endtask

    task automatic t_qpsk_all();
        for (int v = 0; v < 16; v++) begin
            push(4'(v), v == 0, 1'b1);
            expect_qpsk("R5 R2", 4'(v));
        end
    endtask

    task automatic t_midframe_switch();
        push(4'hA, 1'b1, 1'b0);
        expect_qam16("R6 sof qam16", 4'hA);
        push(4'h3, 1'b0, 1'b1);
        expect_qam16("R6 mid-frame ignored", 4'h3);
        push(4'hC, 1'b0, 1'b1);
        expect_qam16("R6 mid-frame ignored 2", 4'hC);
        push(4'h6, 1'b1, 1'b1);
        expect_qpsk("R6 new frame qpsk", 4'h6);
        push(4'h9, 1'b0, 1'b0);
        expect_qpsk("R6 qpsk held", 4'h9);
        push(4'h5, 1'b1, 1'b0);
        expect_qam16("R6 back to qam16", 4'h5);
    endtask

    task automatic t_idle_hold();
        push(4'h7, 1'b1, 1'b1);
        expect_qpsk("R8 setup", 4'h7);
        @(negedge clk);
        in_valid = 1'b0; in_bits = 4'h0; in_sof = 1'b1; mode_sel = 1'b0;
        @(negedge clk);
        chk("R8 out_valid", int'(out_valid), 0);
        chk("R8 s2_active", int'(s2_active), 0);
        chk("R8 s1_i held", int'($signed(s1_i)), bit_lvl(1'b0));
        chk("R8 s2_q held", int'($signed(s2_q)), bit_lvl(1'b1));
        // idle cycle with sof must not have changed the mode either
        push(4'hE, 1'b0, 1'b0);
        expect_qpsk("R8 R6 idle sof ignored", 4'hE);
    endtask

    task automatic t_default_after_reset();
        do_reset();
        push(4'h2, 1'b0, 1'b1);
        expect_qam16("R7 default qam16", 4'h2);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_sof = 1'b0; in_bits = '0; mode_sel = 1'b0;
        t_reset();
        t_qam16_all();
        t_qpsk_all();
        t_midframe_switch();
        t_idle_hold();
        t_default_after_reset();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule